// File: doc/BRIEF.md
# Quad-Lane Dual-Width Byte FIFO

This block buffers data between a processor-facing register interface and a serial shift engine. Storage is four byte-wide lanes of equal depth, 16 entries each by default. The host can reach the storage in two widths. A 32-bit word port pushes or pops one byte in every lane in the same cycle, so the block holds 64 bytes. A byte port works on lane 0 alone, so the block holds 16 bytes.

The serial side moves one byte per accepted strobe. In word mode it visits the lanes in the order 0, 1, 2, 3 and then wraps to lane 0. In byte mode it stays on lane 0. The same block serves either direction of a controller. For transmit, the host pushes and the serial side pops. For receive, the serial side pushes and the host pops.

Both widths get their own full, half-full, empty and data-available flags. A push or pop that cannot be honoured is dropped and reported as a one-cycle illegal-access pulse. Data outputs are show-ahead: each one always shows the head byte of its lane.

Top module: `quad_lane_fifo`

## Requirements
- R1: A word push stores bits 8k+7:8k in lane k, for k = 0 to 3. `hw_pop_data` bits 8k+7:8k always show the head byte of lane k. Each lane is first-in first-out.
- R2: The byte port touches only lane 0. `hb_pop_data` is the head byte of lane 0. A byte pop with lanes 1 to 3 empty is legal.
- R3: With 16-entry lanes, the word port accepts 16 words. `w_full` is 1 when any lane holds 16 bytes.
- R4: When `word_mode` is 1, each accepted serial push advances the serial write lane by one, in the order 0, 1, 2, 3, 0, and each accepted serial pop does the same for the read lane. When `word_mode` is 0, both serial lanes are held at lane 0. `sr_push_lane` and `sr_pop_lane` show the current lanes.
- R5: `w_avail` is 1 only when all four lanes hold at least one byte.
- R6: The byte flags follow the count of lane 0. `b_empty` is 1 at 0 bytes. `b_avail` is 1 at 1 byte or more. `b_half` is 1 at 8 bytes or more. `b_full` is 1 at 16 bytes.
- R7: `w_empty` is 1 when every lane is empty. `w_half` is 1 when the four lanes together hold 32 bytes or more.
- R8: These requests are ignored, leave the contents unchanged, and make `illegal` high for exactly the one cycle after the clock edge that sampled them:
  - a word push while any lane is full;
  - a byte push while lane 0 is full;
  - a serial push while its lane is full;
  - a word pop while any lane is empty;
  - a byte pop while lane 0 is empty;
  - a serial pop while its lane is empty.
- R9: A push and a pop that reach the same lane in one cycle both take effect. Full and empty are judged on the state before that edge. So a push to a full lane is still refused when a pop happens in the same cycle, and a pop from an empty lane is still refused when a push happens in the same cycle.
- R10: When more than one push is requested in a cycle, only the highest-priority one is served, in the order word, byte, serial. The others are dropped and raise `illegal`. Pops follow the same priority.
- R11: After reset every lane is empty, `w_empty` and `b_empty` are 1, all other flags and `illegal` are 0, and both serial lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_mode | input | 1 | 1: the serial side rotates over the four lanes; 0: the serial side uses lane 0 |
| hw_push | input | 1 | Word push strobe |
| hw_push_data | input | 32 | Word to push, byte k to lane k |
| hw_pop | input | 1 | Word pop strobe |
| hw_pop_data | output | 32 | Head bytes of the four lanes |
| hb_push | input | 1 | Byte push strobe (lane 0) |
| hb_push_data | input | 8 | Byte to push |
| hb_pop | input | 1 | Byte pop strobe (lane 0) |
| hb_pop_data | output | 8 | Head byte of lane 0 |
| sr_push | input | 1 | Serial-side push strobe |
| sr_push_data | input | 8 | Serial byte to push |
| sr_push_ready | output | 1 | The serial write lane has room |
| sr_push_lane | output | 2 | Current serial write lane |
| sr_pop | input | 1 | Serial-side pop strobe |
| sr_pop_data | output | 8 | Head byte of the serial read lane |
| sr_pop_valid | output | 1 | The serial read lane holds data |
| sr_pop_lane | output | 2 | Current serial read lane |
| w_full | output | 1 | Word width full |
| w_half | output | 1 | Word width half full |
| w_empty | output | 1 | All lanes empty |
| w_avail | output | 1 | A whole word is available |
| b_full | output | 1 | Lane 0 full |
| b_half | output | 1 | Lane 0 half full |
| b_empty | output | 1 | Lane 0 empty |
| b_avail | output | 1 | A byte is available in lane 0 |
| illegal | output | 1 | One-cycle pulse after a refused or dropped access |

## Verification
The two functions most likely to meet in one cycle are a push and a pop on the same lane. This happens whenever the host and the serial side are both active, and also when the host drives both strobes at once. The bench provokes this four ways:
- on a lane that holds some data;
- on a full lane;
- on an empty lane;
- as competing requests of different priority.

It judges the result at the ports. It checks the `illegal` pulse one cycle later and the updated flags. It then drains the lanes and compares every head byte with the order the requirements predict, which shows which request was honoured and that the dropped one left nothing behind.

// File: rtl/qlf_pkg.sv
package qlf_pkg;
  localparam int unsigned LANES      = 4;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LANE_IDX_W = 2;
  localparam int unsigned WORD_W     = LANES * BYTE_W;

  typedef logic [BYTE_W-1:0]     byte_t;
  typedef logic [LANE_IDX_W-1:0] lane_idx_t;
endpackage

// File: rtl/qlf_lane.sv
module qlf_lane
  import qlf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  byte_t                        data_i,
  input  logic                         pop_i,
  output byte_t                        head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  byte_t           mem_q [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  // R8
  lane_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    push_i |-> (cnt_q != CW'(DEPTH)));

  // R8
  lane_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));

  // R9
  lane_push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/qlf_flags.sv
module qlf_flags
  import qlf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic [LANES-1:0][$clog2(DEPTH+1)-1:0] counts_i,
  output logic [LANES-1:0]                      lane_full_o,
  output logic [LANES-1:0]                      lane_empty_o,
  output logic                                  w_full_o,
  output logic                                  w_half_o,
  output logic                                  w_empty_o,
  output logic                                  w_avail_o,
  output logic                                  b_full_o,
  output logic                                  b_half_o,
  output logic                                  b_empty_o,
  output logic                                  b_avail_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned TW = CW + LANE_IDX_W;

  logic [TW-1:0] total;

  always_comb begin
    total = '0;
    for (int k = 0; k < int'(LANES); k++) begin
      lane_full_o[k]  = (counts_i[k] == CW'(DEPTH));
      lane_empty_o[k] = (counts_i[k] == '0);
      total           = total + TW'(counts_i[k]);
    end
  end

  assign w_full_o  = |lane_full_o;
  assign w_empty_o = &lane_empty_o;
  assign w_avail_o = ~|lane_empty_o;
  assign w_half_o  = (total >= TW'(LANES * DEPTH / 2));
  assign b_full_o  = lane_full_o[0];
  assign b_empty_o = lane_empty_o[0];
  assign b_avail_o = ~lane_empty_o[0];
  assign b_half_o  = (counts_i[0] >= CW'(DEPTH / 2));
endmodule

// File: rtl/qlf_steer.sv
module qlf_steer
  import qlf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    word_mode_i,
  input  logic                    hw_push_i,
  input  logic [WORD_W-1:0]       hw_push_data_i,
  input  logic                    hb_push_i,
  input  byte_t                   hb_push_data_i,
  input  logic                    sr_push_i,
  input  byte_t                   sr_push_data_i,
  input  logic                    hw_pop_i,
  input  logic                    hb_pop_i,
  input  logic                    sr_pop_i,
  input  logic [LANES-1:0]        lane_full_i,
  input  logic [LANES-1:0]        lane_empty_i,
  output logic [LANES-1:0]        lane_push_o,
  output logic [LANES-1:0][BYTE_W-1:0] lane_wdata_o,
  output logic [LANES-1:0]        lane_pop_o,
  output lane_idx_t               sr_wr_lane_o,
  output lane_idx_t               sr_rd_lane_o,
  output logic                    illegal_o
);
  lane_idx_t wr_lane_q, wr_lane_d, rd_lane_q, rd_lane_d;
  logic      illegal_q, illegal_d;
  logic      push_bad, pop_bad, sr_push_ok, sr_pop_ok;

  always_comb begin
    lane_push_o = '0;
    push_bad    = 1'b0;
    sr_push_ok  = 1'b0;
    for (int k = 0; k < int'(LANES); k++) begin
      lane_wdata_o[k] = hw_push_data_i[k*BYTE_W +: BYTE_W];
    end
    if (hw_push_i) begin
      push_bad = hb_push_i | sr_push_i | (|lane_full_i);
      if (~|lane_full_i) lane_push_o = '1;
    end else if (hb_push_i) begin
      push_bad = sr_push_i | lane_full_i[0];
      if (!lane_full_i[0]) begin
        lane_push_o[0]  = 1'b1;
        lane_wdata_o[0] = hb_push_data_i;
      end
    end else if (sr_push_i) begin
      push_bad = lane_full_i[wr_lane_q];
      if (!lane_full_i[wr_lane_q]) begin
        lane_push_o[wr_lane_q]  = 1'b1;
        lane_wdata_o[wr_lane_q] = sr_push_data_i;
        sr_push_ok              = 1'b1;
      end
    end
  end

  always_comb begin
    lane_pop_o = '0;
    pop_bad    = 1'b0;
    sr_pop_ok  = 1'b0;
    if (hw_pop_i) begin
      pop_bad = hb_pop_i | sr_pop_i | (|lane_empty_i);
      if (~|lane_empty_i) lane_pop_o = '1;
    end else if (hb_pop_i) begin
      pop_bad = sr_pop_i | lane_empty_i[0];
      if (!lane_empty_i[0]) lane_pop_o[0] = 1'b1;
    end else if (sr_pop_i) begin
      pop_bad = lane_empty_i[rd_lane_q];
      if (!lane_empty_i[rd_lane_q]) begin
        lane_pop_o[rd_lane_q] = 1'b1;
        sr_pop_ok             = 1'b1;
      end
    end
  end

  always_comb begin
    illegal_d = push_bad | pop_bad;
    if (!word_mode_i) begin
      wr_lane_d = '0;
      rd_lane_d = '0;
    end else begin
      wr_lane_d = sr_push_ok ? wr_lane_q + 1'b1 : wr_lane_q;
      rd_lane_d = sr_pop_ok  ? rd_lane_q + 1'b1 : rd_lane_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_lane_q <= '0;
      rd_lane_q <= '0;
      illegal_q <= 1'b0;
    end else begin
      wr_lane_q <= wr_lane_d;
      rd_lane_q <= rd_lane_d;
      illegal_q <= illegal_d;
    end
  end

  assign sr_wr_lane_o = wr_lane_q;
  assign sr_rd_lane_o = rd_lane_q;
  assign illegal_o    = illegal_q;

  // R10
  push_prio_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hw_push_i && (hb_push_i || sr_push_i)) |=> illegal_o);

  // R8
  word_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hw_pop_i && (|lane_empty_i)) |=> illegal_o);

  // R4
  rot_advance_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (word_mode_i && sr_push_i && !hw_push_i && !hb_push_i && !lane_full_i[wr_lane_q])
    |=> (wr_lane_q == ($past(wr_lane_q) + 2'd1)));

  // R4
  byte_mode_lane_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !word_mode_i |=> ((wr_lane_q == '0) && (rd_lane_q == '0)));

  // R10
  single_push_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (hb_push_i && sr_push_i && !hw_push_i) |-> (lane_push_o[LANES-1:1] == '0));
endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo
  import qlf_pkg::*;
#(
  parameter int unsigned LANE_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_mode,
  input  logic        hw_push,
  input  logic [31:0] hw_push_data,
  input  logic        hw_pop,
  output logic [31:0] hw_pop_data,
  input  logic        hb_push,
  input  logic [7:0]  hb_push_data,
  input  logic        hb_pop,
  output logic [7:0]  hb_pop_data,
  input  logic        sr_push,
  input  logic [7:0]  sr_push_data,
  output logic        sr_push_ready,
  output logic [1:0]  sr_push_lane,
  input  logic        sr_pop,
  output logic [7:0]  sr_pop_data,
  output logic        sr_pop_valid,
  output logic [1:0]  sr_pop_lane,
  output logic        w_full,
  output logic        w_half,
  output logic        w_empty,
  output logic        w_avail,
  output logic        b_full,
  output logic        b_half,
  output logic        b_empty,
  output logic        b_avail,
  output logic        illegal
);
  localparam int unsigned CW = $clog2(LANE_DEPTH + 1);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [LANES-1:0][CW-1:0]     counts;
  logic [LANES-1:0][BYTE_W-1:0] heads;
  logic [LANES-1:0][BYTE_W-1:0] lane_wdata;
  logic [LANES-1:0]             lane_push, lane_pop, lane_full, lane_empty;
  lane_idx_t                    wr_lane, rd_lane;

  qlf_steer u_steer (
    .clk            (clk),
    .rst_ni         (rst_sync_q),
    .word_mode_i    (word_mode),
    .hw_push_i      (hw_push),
    .hw_push_data_i (hw_push_data),
    .hb_push_i      (hb_push),
    .hb_push_data_i (hb_push_data),
    .sr_push_i      (sr_push),
    .sr_push_data_i (sr_push_data),
    .hw_pop_i       (hw_pop),
    .hb_pop_i       (hb_pop),
    .sr_pop_i       (sr_pop),
    .lane_full_i    (lane_full),
    .lane_empty_i   (lane_empty),
    .lane_push_o    (lane_push),
    .lane_wdata_o   (lane_wdata),
    .lane_pop_o     (lane_pop),
    .sr_wr_lane_o   (wr_lane),
    .sr_rd_lane_o   (rd_lane),
    .illegal_o      (illegal)
  );

  for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
    qlf_lane #(.DEPTH(LANE_DEPTH)) u_lane (
      .clk     (clk),
      .rst_ni  (rst_sync_q),
      .push_i  (lane_push[k]),
      .data_i  (lane_wdata[k]),
      .pop_i   (lane_pop[k]),
      .head_o  (heads[k]),
      .count_o (counts[k])
    );
    assign hw_pop_data[k*BYTE_W +: BYTE_W] = heads[k];
  end

  qlf_flags #(.DEPTH(LANE_DEPTH)) u_flags (
    .counts_i     (counts),
    .lane_full_o  (lane_full),
    .lane_empty_o (lane_empty),
    .w_full_o     (w_full),
    .w_half_o     (w_half),
    .w_empty_o    (w_empty),
    .w_avail_o    (w_avail),
    .b_full_o     (b_full),
    .b_half_o     (b_half),
    .b_empty_o    (b_empty),
    .b_avail_o    (b_avail)
  );

  assign hb_pop_data   = heads[0];
  assign sr_pop_data   = heads[rd_lane];
  assign sr_push_ready = ~lane_full[wr_lane];
  assign sr_pop_valid  = ~lane_empty[rd_lane];
  assign sr_push_lane  = wr_lane;
  assign sr_pop_lane   = rd_lane;

  // R5
  word_avail_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    w_avail |-> (b_avail && !w_empty));

  // R8
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!hw_push && !hb_push && !sr_push && !hw_pop && !hb_pop && !sr_pop) |=> !illegal);
endmodule

// File: tb/quad_lane_fifo_tb_top.sv
module quad_lane_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_mode;
  logic        hw_push, hw_pop, hb_push, hb_pop, sr_push, sr_pop;
  logic [31:0] hw_push_data, hw_pop_data;
  logic [7:0]  hb_push_data, hb_pop_data, sr_push_data, sr_pop_data;
  logic        sr_push_ready, sr_pop_valid;
  logic [1:0]  sr_push_lane, sr_pop_lane;
  logic        w_full, w_half, w_empty, w_avail, b_full, b_half, b_empty, b_avail, illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  quad_lane_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .hw_push(hw_push), .hw_push_data(hw_push_data), .hw_pop(hw_pop), .hw_pop_data(hw_pop_data),
    .hb_push(hb_push), .hb_push_data(hb_push_data), .hb_pop(hb_pop), .hb_pop_data(hb_pop_data),
    .sr_push(sr_push), .sr_push_data(sr_push_data), .sr_push_ready(sr_push_ready),
    .sr_push_lane(sr_push_lane), .sr_pop(sr_pop), .sr_pop_data(sr_pop_data),
    .sr_pop_valid(sr_pop_valid), .sr_pop_lane(sr_pop_lane),
    .w_full(w_full), .w_half(w_half), .w_empty(w_empty), .w_avail(w_avail),
    .b_full(b_full), .b_half(b_half), .b_empty(b_empty), .b_avail(b_avail),
    .illegal(illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wpush(input logic [31:0] d);
    hw_push = 1'b1; hw_push_data = d;
    @(negedge clk); hw_push = 1'b0;
  endtask

  task automatic wpop_chk(input string req, input logic [31:0] exp);
    chk(req, hw_pop_data, exp);
    hw_pop = 1'b1;
    @(negedge clk); hw_pop = 1'b0;
  endtask

  task automatic bpush(input logic [7:0] d);
    hb_push = 1'b1; hb_push_data = d;
    @(negedge clk); hb_push = 1'b0;
  endtask

  task automatic bpop_chk(input string req, input logic [7:0] exp);
    chk(req, {24'h0, hb_pop_data}, {24'h0, exp});
    hb_pop = 1'b1;
    @(negedge clk); hb_pop = 1'b0;
  endtask

  task automatic spush(input string req, input logic [7:0] d, input logic [1:0] lane);
    chk(req, {30'h0, sr_push_lane}, {30'h0, lane});
    sr_push = 1'b1; sr_push_data = d;
    @(negedge clk); sr_push = 1'b0;
  endtask

  task automatic spop_chk(input string req, input logic [1:0] lane, input logic [7:0] exp);
    chk(req, {30'h0, sr_pop_lane}, {30'h0, lane});
    chk(req, {31'h0, sr_pop_valid}, 32'h1);
    chk(req, {24'h0, sr_pop_data}, {24'h0, exp});
    sr_pop = 1'b1;
    @(negedge clk); sr_pop = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 w_empty", {31'h0, w_empty}, 32'h1);
    chk("R11 b_empty", {31'h0, b_empty}, 32'h1);
    chk("R11 other flags", {28'h0, w_full, w_half, w_avail, b_full}, 32'h0);
    chk("R11 byte flags", {29'h0, b_half, b_avail, illegal}, 32'h0);
    chk("R11 serial lanes", {28'h0, sr_push_lane, sr_pop_lane}, 32'h0);
  endtask

  task automatic t_word_order;
    wpush(32'h44332211);
    wpush(32'h88776655);
    chk("R5 w_avail after word", {31'h0, w_avail}, 32'h1);
    chk("R2 b_avail after word", {31'h0, b_avail}, 32'h1);
    wpop_chk("R1 word 0", 32'h44332211);
    wpop_chk("R1 word 1", 32'h88776655);
    chk("R7 w_empty drained", {31'h0, w_empty}, 32'h1);
  endtask

  task automatic t_byte_port;
    bpush(8'h21); bpush(8'h22); bpush(8'h23);
    chk("R5 no word from bytes", {31'h0, w_avail}, 32'h0);
    chk("R6 b_avail", {31'h0, b_avail}, 32'h1);
    chk("R6 b_half low", {31'h0, b_half}, 32'h0);
    hw_pop = 1'b1;
    @(negedge clk); hw_pop = 1'b0;
    chk("R8 word pop on partial", {31'h0, illegal}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'h0, illegal}, 32'h0);
    bpop_chk("R2 byte 0", 8'h21);
    bpop_chk("R2 byte 1", 8'h22);
    bpop_chk("R2 byte 2", 8'h23);
    chk("R6 b_empty", {31'h0, b_empty}, 32'h1);
  endtask

  task automatic t_word_capacity;
    for (int i = 0; i < 16; i++) begin
      wpush(32'hA0B0C0D0 + 32'h01010101 * i);
      if (i == 6) chk("R7 w_half below", {31'h0, w_half}, 32'h0);
      if (i == 7) chk("R7 w_half at 32", {31'h0, w_half}, 32'h1);
    end
    chk("R3 w_full", {31'h0, w_full}, 32'h1);
    chk("R6 b_full", {31'h0, b_full}, 32'h1);
    wpush(32'hDEADBEEF);
    chk("R8 push full word", {31'h0, illegal}, 32'h1);
    for (int i = 0; i < 16; i++) wpop_chk("R3 word drain", 32'hA0B0C0D0 + 32'h01010101 * i);
    chk("R3 no extra word", {31'h0, w_empty}, 32'h1);
  endtask

  task automatic t_byte_capacity;
    for (int i = 0; i < 16; i++) begin
      bpush(8'h80 + 8'(i));
      if (i == 6) chk("R6 b_half below", {31'h0, b_half}, 32'h0);
      if (i == 7) chk("R6 b_half at 8", {31'h0, b_half}, 32'h1);
    end
    chk("R6 b_full", {31'h0, b_full}, 32'h1);
    chk("R3 w_full any lane", {31'h0, w_full}, 32'h1);
    chk("R7 w_half by total", {31'h0, w_half}, 32'h0);
    bpush(8'hEE);
    chk("R8 push full byte", {31'h0, illegal}, 32'h1);
    for (int i = 0; i < 16; i++) bpop_chk("R2 byte drain", 8'h80 + 8'(i));
    chk("R8 no extra byte", {31'h0, b_empty}, 32'h1);
  endtask

  task automatic t_serial_word;
    word_mode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      spush("R4 push lane", 8'h10 + 8'(i), 2'(i));
      if (i == 2) chk("R5 three lanes", {31'h0, w_avail}, 32'h0);
      if (i == 3) chk("R5 four lanes", {31'h0, w_avail}, 32'h1);
    end
    wpop_chk("R1 serial assembled 0", 32'h13121110);
    wpop_chk("R1 serial assembled 1", 32'h17161514);
    wpush(32'hC3C2C1C0);
    for (int i = 0; i < 4; i++) spop_chk("R4 pop lane", 2'(i), 8'hC0 + 8'(i));
    chk("R4 pop lane wrap", {30'h0, sr_pop_lane}, 32'h0);
    chk("R7 empty after serial", {31'h0, w_empty}, 32'h1);
  endtask

  task automatic t_serial_byte;
    word_mode = 1'b0;
    @(negedge clk);
    spush("R4 byte mode lane", 8'h5A, 2'd0);
    spush("R4 byte mode lane", 8'h5B, 2'd0);
    chk("R5 no word in byte mode", {31'h0, w_avail}, 32'h0);
    bpop_chk("R4 byte mode data", 8'h5A);
    bpop_chk("R4 byte mode data", 8'h5B);
    bpush(8'h66);
    spop_chk("R4 byte mode pop", 2'd0, 8'h66);
    sr_pop = 1'b1;
    @(negedge clk); sr_pop = 1'b0;
    chk("R8 serial pop empty", {31'h0, illegal}, 32'h1);
  endtask

  task automatic t_same_cycle;
    wpush(32'hABABABAB);
    chk("R9 head before", hw_pop_data, 32'hABABABAB);
    hw_push = 1'b1; hw_push_data = 32'hCDCDCDCD; hw_pop = 1'b1;
    @(negedge clk); hw_push = 1'b0; hw_pop = 1'b0;
    chk("R9 push+pop legal", {31'h0, illegal}, 32'h0);
    wpop_chk("R9 new head", 32'hCDCDCDCD);
    chk("R9 empty after", {31'h0, w_empty}, 32'h1);
    for (int i = 0; i < 16; i++) bpush(8'h40 + 8'(i));
    chk("R9 head full", {24'h0, hb_pop_data}, 32'h40);
    hb_push = 1'b1; hb_push_data = 8'hEE; hb_pop = 1'b1;
    @(negedge clk); hb_push = 1'b0; hb_pop = 1'b0;
    chk("R9 full push refused", {31'h0, illegal}, 32'h1);
    chk("R9 full pop taken", {31'h0, b_full}, 32'h0);
    for (int i = 1; i < 16; i++) bpop_chk("R9 full drain", 8'h40 + 8'(i));
    chk("R9 no EE stored", {31'h0, b_empty}, 32'h1);
    hb_push = 1'b1; hb_push_data = 8'h77; hb_pop = 1'b1;
    @(negedge clk); hb_push = 1'b0; hb_pop = 1'b0;
    chk("R9 empty pop refused", {31'h0, illegal}, 32'h1);
    bpop_chk("R9 empty push taken", 8'h77);
  endtask

  task automatic t_priority;
    hw_push = 1'b1; hw_push_data = 32'h0D0C0B0A; hb_push = 1'b1; hb_push_data = 8'h99;
    @(negedge clk); hw_push = 1'b0; hb_push = 1'b0;
    chk("R10 push clash", {31'h0, illegal}, 32'h1);
    wpop_chk("R10 word won", 32'h0D0C0B0A);
    chk("R10 byte dropped", {31'h0, b_empty}, 32'h1);
    word_mode = 1'b1;
    wpush(32'h33221100);
    hw_pop = 1'b1; sr_pop = 1'b1;
    @(negedge clk); hw_pop = 1'b0; sr_pop = 1'b0;
    chk("R10 pop clash", {31'h0, illegal}, 32'h1);
    chk("R10 serial lane held", {30'h0, sr_pop_lane}, 32'h0);
    chk("R10 word pop won", {31'h0, w_empty}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; word_mode = 1'b0;
    hw_push = 1'b0; hw_pop = 1'b0; hb_push = 1'b0; hb_pop = 1'b0;
    sr_push = 1'b0; sr_pop = 1'b0;
    hw_push_data = '0; hb_push_data = '0; sr_push_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_word_order();
    t_byte_port();
    t_word_capacity();
    t_byte_capacity();
    t_serial_word();
    t_serial_byte();
    t_same_cycle();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule